// File: doc/BRIEF.md
# Selectable IR Carrier Generator

This block produces the modulation carrier for an infrared remote-control emitter. A 3-bit mode value picks one of seven fixed carrier shapes, each counted directly in oscillator clock cycles, or an eighth setting that turns the pin into a plain static output. The output pin is modelled as an open-drain pull-down with its own high-impedance indication. Software frames the protocol by switching the output on and off with set and clear strobes. The carrier shape is chosen through the mode write port.

Each carrier period starts with its active (pulling) phase. A new mode written while the carrier runs waits for the end of the current period, so a partial pulse never appears on the pin. While the output is off, or while the chip is in stop mode, the phase counter is held at zero. The first pulse after the output comes back is therefore always complete.

Top module: `ir_carrier_gen`

## Requirements
- R1: After reset the pin is released (`ir_hiz_o`=1, `ir_drive_o`=0), and the selected mode is 0.
- R2: Carrier modes, given as (period in cycles, active cycles): 0=(96,48), 1=(96,32), 2=(64,32), 3=(64,16), 4=(88,32), 6=(96,24), 7=(92,46). `ir_drive_o` is 1 for the first active-cycle count of each period and 0 for the rest of it.
- R3: The first clock after the output turns on is the first cycle of a full active phase, so `ir_drive_o`=1 whenever the pin leaves high impedance.
- R4: Mode 5 is static. While it is enabled, `ir_drive_o` stays at 1 with no toggling. While it is disabled, the pin is released.
- R5: `out_set_i` turns the output on from the next cycle. `out_clr_i` turns it off from the next cycle. When both strobes are high in the same cycle, clear wins.
- R6: While `stop_i` is high, the pin is released at once, whatever the enable state. The phase counter is held at zero during stop. After stop falls, the carrier restarts at the beginning of an active phase.
- R7: A mode write while the carrier runs takes effect only at the next period boundary. The current period finishes with the old shape.
- R8: A mode write while the output is off, stopped or in static mode takes effect on the next clock.
- R9: `ir_drive_o` is never 1 while `ir_hiz_o` is 1, and the phase count never reaches the largest period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_val_i | input | 3 | Mode value written with the strobe |
| out_set_i | input | 1 | Turn the output on |
| out_clr_i | input | 1 | Turn the output off (wins over set) |
| stop_i | input | 1 | Stop-mode flag; releases the pin |
| ir_drive_o | output | 1 | 1 = pull-down transistor conducts |
| ir_hiz_o | output | 1 | 1 = output transistor disabled |

## Verification
The bench walks every carrier mode from a cold enable and compares each cycle of two full periods. Errors it targets include an off-by-one terminal count, which would stretch or shrink the period, and a duty slip, which would move the falling edge. It changes the mode halfway through a period. A design that loads the new mode at once would cut the pulse short at the wrong cycle. The bench also raises stop partway into an active phase and writes a new mode during the stop. A design that did not clear the counter would resume mid-period, and one that ignored the write would come back with the old shape. Further cases are set and clear strobes in the same cycle, and an entry into static mode at a period boundary. A design that got these wrong would leave the pin enabled, or would keep toggling after the boundary.

// File: rtl/ircg_pkg.sv
package ircg_pkg;

  localparam int MODE_W     = 3;
  localparam int MAX_PERIOD = 96;
  localparam int CNT_W      = $clog2(MAX_PERIOD);

  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  localparam mode_t STATIC_MODE = mode_t'(5);

  // hold: no carrier; last: terminal count (period-1); high: active cycles
  typedef struct packed {
    logic hold;
    cnt_t last;
    cnt_t high;
  } shape_t;

  function automatic shape_t shape_of(mode_t m);
    shape_t s;
    s.hold = 1'b0;
    s.last = '0;
    s.high = '0;
    case (m)
      mode_t'(0): begin s.last = cnt_t'(95); s.high = cnt_t'(48); end
      mode_t'(1): begin s.last = cnt_t'(95); s.high = cnt_t'(32); end
      mode_t'(2): begin s.last = cnt_t'(63); s.high = cnt_t'(32); end
      mode_t'(3): begin s.last = cnt_t'(63); s.high = cnt_t'(16); end
      mode_t'(4): begin s.last = cnt_t'(87); s.high = cnt_t'(32); end
      mode_t'(6): begin s.last = cnt_t'(95); s.high = cnt_t'(24); end
      mode_t'(7): begin s.last = cnt_t'(91); s.high = cnt_t'(46); end
      default:    begin s.hold = 1'b1; end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ircg_mode_sel.sv
module ircg_mode_sel
  import ircg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  mode_t wr_mode_i,
  input  logic  load_i,
  output mode_t act_mode_o
);

  mode_t pend_q, pend_d;
  mode_t act_q, act_d;

  always_comb begin
    pend_d = pend_q;
    if (wr_i) pend_d = wr_mode_i;
    act_d = act_q;
    if (load_i) act_d = pend_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign act_mode_o = act_q;

endmodule

// File: rtl/ircg_phase_cnt.sv
module ircg_phase_cnt
  import ircg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  input  shape_t shape_i,
  output cnt_t   cnt_o,
  output logic   wrap_o,
  output logic   active_o
);

  cnt_t cnt_q, cnt_d;
  logic wrap;

  assign wrap = run_i && !shape_i.hold && (cnt_q == shape_i.last);

  always_comb begin
    if (!run_i || shape_i.hold || wrap) cnt_d = '0;
    else                                cnt_d = cnt_q + cnt_t'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o    = cnt_q;
  assign wrap_o   = wrap;
  assign active_o = run_i && (shape_i.hold || (cnt_q < shape_i.high));

endmodule

// File: rtl/ircg_out_stage.sv
module ircg_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic stop_i,
  input  logic active_i,
  output logic run_o,
  output logic drive_o,
  output logic hiz_o
);

  logic en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (clr_i)      en_d = 1'b0;
    else if (set_i) en_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_d;
  end

  assign run_o   = en_q && !stop_i;
  assign hiz_o   = !run_o;
  assign drive_o = run_o && active_i;

endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
  import ircg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_val_i,
  input  logic              out_set_i,
  input  logic              out_clr_i,
  input  logic              stop_i,
  output logic              ir_drive_o,
  output logic              ir_hiz_o
);

  mode_t  act_mode;
  shape_t shape;
  cnt_t   cnt;
  logic   wrap, active, run, load;

  assign shape = shape_of(act_mode);
  assign load  = !run || shape.hold || wrap;

  ircg_mode_sel u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (mode_wr_i),
    .wr_mode_i  (mode_val_i),
    .load_i     (load),
    .act_mode_o (act_mode)
  );

  ircg_phase_cnt u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .shape_i  (shape),
    .cnt_o    (cnt),
    .wrap_o   (wrap),
    .active_o (active)
  );

  ircg_out_stage u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (out_set_i),
    .clr_i    (out_clr_i),
    .stop_i   (stop_i),
    .active_i (active),
    .run_o    (run),
    .drive_o  (ir_drive_o),
    .hiz_o    (ir_hiz_o)
  );

endmodule

// File: rtl/ircg_chk.sv
module ircg_chk
  import ircg_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  out_set_i,
  input logic  out_clr_i,
  input logic  stop_i,
  input logic  ir_drive_o,
  input logic  ir_hiz_o,
  input mode_t act_mode,
  input cnt_t  cnt,
  input logic  wrap,
  input logic  run
);

  // R9
  no_drive_while_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_hiz_o |-> !ir_drive_o);

  // R9
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < cnt_t'(MAX_PERIOD));

  // R6
  stop_releases_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> (ir_hiz_o && !ir_drive_o));

  // R5
  clear_disables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_clr_i |=> ir_hiz_o);

  // R5
  set_enables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_set_i && !out_clr_i && !stop_i) |=> (!ir_hiz_o || stop_i));

  // R3
  first_cycle_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ir_hiz_o && $past(ir_hiz_o)) |-> ir_drive_o);

  // R4
  static_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && act_mode == STATIC_MODE) |-> ir_drive_o);

  // R7
  mode_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(act_mode) && $past(run) && $past(act_mode) != STATIC_MODE) |-> $past(wrap));

endmodule

bind ir_carrier_gen ircg_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .out_set_i  (out_set_i),
  .out_clr_i  (out_clr_i),
  .stop_i     (stop_i),
  .ir_drive_o (ir_drive_o),
  .ir_hiz_o   (ir_hiz_o),
  .act_mode   (act_mode),
  .cnt        (cnt),
  .wrap       (wrap),
  .run        (run)
);

// File: tb/ir_carrier_gen_tb.sv
module ir_carrier_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_wr;
  logic [2:0] mode_val;
  logic       out_set, out_clr, stop;
  logic       drive, hiz;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ir_carrier_gen u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mode_wr_i  (mode_wr),
    .mode_val_i (mode_val),
    .out_set_i  (out_set),
    .out_clr_i  (out_clr),
    .stop_i     (stop),
    .ir_drive_o (drive),
    .ir_hiz_o   (hiz)
  );

  task automatic chk(string req, logic [1:0] got, logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: {hiz,drive} actual=%b expected=%b", req, $time, got, exp);
    end
  endtask

  // Samples at the current falling edge, then moves one cycle on.
  task automatic check_wave(string req, int per, int hi, int first, int n);
    for (int i = 0; i < n; i++) begin
      int idx = first + i;
      chk(req, {hiz, drive}, {1'b0, ((idx % per) < hi) ? 1'b1 : 1'b0});
      @(negedge clk);
    end
  endtask

  task automatic write_mode(logic [2:0] m);
    mode_wr = 1'b1; mode_val = m;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic turn_on();
    out_set = 1'b1;
    @(negedge clk);
    out_set = 1'b0;
  endtask

  task automatic turn_off();
    out_clr = 1'b1;
    @(negedge clk);
    out_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset", {hiz, drive}, 2'b10);
  endtask

  task automatic t_default_mode();
    turn_on();
    check_wave("R1 default mode 0", 96, 48, 0, 96);
    turn_off();
    chk("R5 clear", {hiz, drive}, 2'b10);
  endtask

  task automatic t_mode_table();
    int pers[7] = '{96, 96, 64, 64, 88, 96, 92};
    int his[7]  = '{48, 32, 32, 16, 32, 24, 46};
    int mds[7]  = '{0, 1, 2, 3, 4, 6, 7};
    for (int k = 0; k < 7; k++) begin
      write_mode(3'(mds[k]));
      turn_on();
      check_wave("R2 R3 R8 mode table", pers[k], his[k], 0, 2 * pers[k]);
      turn_off();
    end
  endtask

  task automatic t_static();
    write_mode(3'd5);
    chk("R4 static off", {hiz, drive}, 2'b10);
    turn_on();
    check_wave("R4 static on", 1, 1, 0, 40);
    turn_off();
    chk("R4 static cleared", {hiz, drive}, 2'b10);
  endtask

  task automatic t_live_change();
    write_mode(3'd2);
    turn_on();
    check_wave("R7 before write", 64, 32, 0, 10);
    mode_wr = 1'b1; mode_val = 3'd3;
    check_wave("R7 write cycle", 64, 32, 10, 1);
    mode_wr = 1'b0;
    check_wave("R7 old shape kept", 64, 32, 11, 53);
    check_wave("R7 new shape", 64, 16, 0, 69);
    mode_wr = 1'b1; mode_val = 3'd5;
    check_wave("R7 static write", 64, 16, 5, 1);
    mode_wr = 1'b0;
    check_wave("R7 finish before static", 64, 16, 6, 58);
    check_wave("R4 R7 static after boundary", 1, 1, 0, 20);
    turn_off();
  endtask

  task automatic t_stop();
    write_mode(3'd0);
    turn_on();
    check_wave("R6 before stop", 96, 48, 0, 5);
    stop = 1'b1;
    #1;
    chk("R6 stop immediate", {hiz, drive}, 2'b10);
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      chk("R6 held in stop", {hiz, drive}, 2'b10);
      @(negedge clk);
    end
    write_mode(3'd2);
    chk("R6 R8 write in stop", {hiz, drive}, 2'b10);
    stop = 1'b0;
    @(negedge clk);
    check_wave("R6 R8 restart full pulse", 64, 32, 1, 130);
    turn_off();
  endtask

  task automatic t_set_clr_same();
    out_set = 1'b1; out_clr = 1'b1;
    @(negedge clk);
    out_set = 1'b0; out_clr = 1'b0;
    chk("R5 both from off", {hiz, drive}, 2'b10);
    turn_on();
    chk("R5 set", {hiz, drive}, 2'b01);
    out_set = 1'b1; out_clr = 1'b1;
    @(negedge clk);
    out_set = 1'b0; out_clr = 1'b0;
    chk("R5 both from on", {hiz, drive}, 2'b10);
  endtask

  initial begin
    rst_n = 1'b0; mode_wr = 1'b0; mode_val = '0;
    out_set = 1'b0; out_clr = 1'b0; stop = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_mode();
    t_mode_table();
    t_static();
    t_live_change();
    t_stop();
    t_set_clr_same();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule